// File: doc/BRIEF.md
# Multi-mode operand address generator

This block turns one decoded instruction into its source operand. The instruction arrives with a four-bit addressing-mode code and three register numbers. The numbers name a first register, a base register and an index register. It also carries a displacement, an immediate and a two-bit access-size code. The block reads the three registers from an external register file in the cycle it accepts the request. It then forms an effective address and fetches the operand from a byte-addressed data memory. The memory has a synchronous read port with one cycle of latency.

Memory-indirect mode chains two reads: the word returned by the first read is the address of the second. The two auto-modify modes write the adjusted base register back to the register file. Auto-increment reads first and then steps the base. Auto-decrement steps the base first and reads at the stepped value. The finished operand and the value of the first register go to the adder stage in a single-cycle valid pulse. The block holds one request at a time.

Top module: `opnd_agen`

## Requirements
- R1: Mode code 0 (register) yields the base register's value as the operand; codes 10 to 15 behave exactly like code 0. Neither touches memory, and the result is valid in the first cycle after acceptance.
- R2: Mode code 1 (immediate) yields the immediate field as the operand, with no memory read, valid in the first cycle after acceptance.
- R3: Mode code 2 (displacement) reads memory at displacement plus base register. Mode code 5 (absolute) reads memory at the displacement field alone. The word read is the operand.
- R4: Mode code 3 (register indirect) reads memory at the base register's value. Mode code 4 (indexed) reads memory at base plus index register.
- R5: Mode code 6 (memory indirect) reads memory at the base register's value. It then issues a second read at the returned word, and the word from that second read is the operand.
- R6: Mode code 7 (auto-increment) reads memory at the base register's old value. In the done cycle it writes the old value plus d to the base register. Here d = 1 << size code, so size codes 0, 1, 2 and 3 give d = 1, 2, 4 and 8.
- R7: Mode code 8 (auto-decrement) reads memory at the base value minus d. In the done cycle it writes that same reduced value to the base register.
- R8: Mode code 9 (scaled) reads memory at displacement plus base plus (index shifted left by the size code).
- R9: The second result output carries the first register's value as read in the acceptance cycle, even when the first register is also the base that gets updated.
- R10: A read is answered one cycle after the cycle in which it is issued. The single-read modes finish in the 3rd cycle after acceptance and memory-indirect finishes in the 5th. Done is a single-cycle pulse. The register write strobe is high only in the done cycle of modes 7 and 8. All arithmetic wraps modulo 2 to the power of the data width.
- R11: Busy is high from the cycle after acceptance through the done cycle and low right after it. A request presented while busy is ignored and does not change the result.
- R12: While reset is asserted, done, busy, the read strobe and the register write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_mode | input | 4 | Addressing-mode code |
| req_size | input | 2 | Access-size code, d = 1 << code |
| req_ra | input | RAW | First register number |
| req_rb | input | RAW | Base register number |
| req_rx | input | RAW | Index register number |
| req_disp | input | DW | Displacement / absolute address |
| req_imm | input | DW | Immediate value |
| busy | output | 1 | Request in progress |
| rf_ra_addr | output | RAW | Register file read address, first register |
| rf_rb_addr | output | RAW | Register file read address, base register |
| rf_rx_addr | output | RAW | Register file read address, index register |
| rf_ra_data | input | DW | Combinational read data, first register |
| rf_rb_data | input | DW | Combinational read data, base register |
| rf_rx_data | input | DW | Combinational read data, index register |
| rf_we | output | 1 | Base register write strobe |
| rf_waddr | output | RAW | Base register write address |
| rf_wdata | output | DW | Updated base value |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | DW | Memory byte address |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |
| out_valid | output | 1 | Done pulse |
| out_operand | output | DW | Source operand |
| out_base | output | DW | First register value for the adder |

## Verification
The bench builds the block with a 16-bit data width and four registers. That makes it practical to sweep all sixteen mode codes and all four size codes over every one of the 64 register-number triples. The triples include every aliasing case, such as first, base and index being the same register. A 16-bit width with pseudo-random register contents and memory words makes address sums, negative steps and chained indirect addresses wrap often. The small register count keeps the full sweep at a few thousand requests. For every request the bench holds a conflicting request on the inputs while the block is busy.

// File: rtl/opnd_agen_pkg.sv
package opnd_agen_pkg;

    // Addressing-mode codes; codes 10..15 fall back to register mode.
    typedef enum logic [3:0] {
        AM_REG   = 4'd0,
        AM_IMM   = 4'd1,
        AM_DISP  = 4'd2,
        AM_RIND  = 4'd3,
        AM_INDEX = 4'd4,
        AM_ABS   = 4'd5,
        AM_MIND  = 4'd6,
        AM_AINC  = 4'd7,
        AM_ADEC  = 4'd8,
        AM_SCALE = 4'd9
    } amode_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_WT1  = 3'd2,
        ST_RD2  = 3'd3,
        ST_WT2  = 3'd4,
        ST_DONE = 3'd5
    } seq_e;

endpackage

// File: rtl/opnd_agen_ea.sv
// Effective-address and base-update computation (purely combinational).
module opnd_agen_ea
    import opnd_agen_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] index_val,
    input  logic [DW-1:0] disp,
    input  logic [DW-1:0] imm,
    output logic          use_mem,
    output logic          chain,
    output logic          upd_en,
    output logic [DW-1:0] upd_val,
    output logic [DW-1:0] mem_ad,
    output logic [DW-1:0] direct_val
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] step;
    logic [DW-1:0] scaled_idx;
    logic [DW-1:0] dec_base;

    always_comb begin
        step       = ONE << size;
        scaled_idx = index_val << size;
        dec_base   = base_val - step;
    end

    always_comb begin
        use_mem    = 1'b1;
        chain      = 1'b0;
        upd_en     = 1'b0;
        upd_val    = base_val;
        mem_ad     = base_val;
        direct_val = base_val;
        case (mode)
            AM_IMM: begin
                use_mem    = 1'b0;
                direct_val = imm;
            end
            AM_DISP: begin
                mem_ad = disp + base_val;
            end
            AM_RIND: begin
                mem_ad = base_val;
            end
            AM_INDEX: begin
                mem_ad = base_val + index_val;
            end
            AM_ABS: begin
                mem_ad = disp;
            end
            AM_MIND: begin
                mem_ad = base_val;
                chain  = 1'b1;
            end
            AM_AINC: begin
                mem_ad  = base_val;
                upd_en  = 1'b1;
                upd_val = base_val + step;
            end
            AM_ADEC: begin
                mem_ad  = dec_base;
                upd_en  = 1'b1;
                upd_val = dec_base;
            end
            AM_SCALE: begin
                mem_ad = disp + base_val + scaled_idx;
            end
            default: begin
                // register mode and unused codes
                use_mem    = 1'b0;
                direct_val = base_val;
            end
        endcase
    end

endmodule

// File: rtl/opnd_agen_seq.sv
// Request sequencer: accept, one or two memory reads, done with writeback.
module opnd_agen_seq
    import opnd_agen_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [RAW-1:0] req_rb,
    input  logic [DW-1:0]  first_val,
    input  logic           use_mem,
    input  logic           chain,
    input  logic           upd_en,
    input  logic [DW-1:0]  upd_val,
    input  logic [DW-1:0]  mem_ad,
    input  logic [DW-1:0]  direct_val,
    input  logic [DW-1:0]  mem_rdata,
    output logic           busy,
    output logic           mem_re,
    output logic [DW-1:0]  mem_addr,
    output logic           out_valid,
    output logic [DW-1:0]  out_operand,
    output logic [DW-1:0]  out_base,
    output logic           rf_we,
    output logic [RAW-1:0] rf_waddr,
    output logic [DW-1:0]  rf_wdata
);

    typedef struct packed {
        seq_e           st;
        logic           chain;
        logic           upd_en;
        logic [RAW-1:0] wreg;
        logic [DW-1:0]  addr;
        logic [DW-1:0]  opnd;
        logic [DW-1:0]  base;
        logic [DW-1:0]  upd;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        case (sq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    sq_d.chain  = chain;
                    sq_d.upd_en = upd_en;
                    sq_d.wreg   = req_rb;
                    sq_d.addr   = mem_ad;
                    sq_d.opnd   = direct_val;
                    sq_d.base   = first_val;
                    sq_d.upd    = upd_val;
                    sq_d.st     = use_mem ? ST_RD1 : ST_DONE;
                end
            end
            ST_RD1: sq_d.st = ST_WT1;
            ST_WT1: begin
                if (sq_q.chain) begin
                    sq_d.addr = mem_rdata;
                    sq_d.st   = ST_RD2;
                end else begin
                    sq_d.opnd = mem_rdata;
                    sq_d.st   = ST_DONE;
                end
            end
            ST_RD2: sq_d.st = ST_WT2;
            ST_WT2: begin
                sq_d.opnd = mem_rdata;
                sq_d.st   = ST_DONE;
            end
            ST_DONE: sq_d.st = ST_IDLE;
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        busy        = (sq_q.st != ST_IDLE);
        mem_re      = (sq_q.st == ST_RD1) || (sq_q.st == ST_RD2);
        mem_addr    = sq_q.addr;
        out_valid   = (sq_q.st == ST_DONE);
        out_operand = sq_q.opnd;
        out_base    = sq_q.base;
        rf_we       = (sq_q.st == ST_DONE) && sq_q.upd_en;
        rf_waddr    = sq_q.wreg;
        rf_wdata    = sq_q.upd;
    end

endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
    import opnd_agen_pkg::*;
#(
    parameter  int DW  = 32,
    parameter  int RN  = 16,
    localparam int RAW = (RN > 1) ? $clog2(RN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [3:0]     req_mode,
    input  logic [1:0]     req_size,
    input  logic [RAW-1:0] req_ra,
    input  logic [RAW-1:0] req_rb,
    input  logic [RAW-1:0] req_rx,
    input  logic [DW-1:0]  req_disp,
    input  logic [DW-1:0]  req_imm,
    output logic           busy,
    output logic [RAW-1:0] rf_ra_addr,
    output logic [RAW-1:0] rf_rb_addr,
    output logic [RAW-1:0] rf_rx_addr,
    input  logic [DW-1:0]  rf_ra_data,
    input  logic [DW-1:0]  rf_rb_data,
    input  logic [DW-1:0]  rf_rx_data,
    output logic           rf_we,
    output logic [RAW-1:0] rf_waddr,
    output logic [DW-1:0]  rf_wdata,
    output logic           mem_re,
    output logic [DW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           out_valid,
    output logic [DW-1:0]  out_operand,
    output logic [DW-1:0]  out_base
);

    logic          ea_use_mem;
    logic          ea_chain;
    logic          ea_upd_en;
    logic [DW-1:0] ea_upd_val;
    logic [DW-1:0] ea_mem_ad;
    logic [DW-1:0] ea_direct;

    assign rf_ra_addr = req_ra;
    assign rf_rb_addr = req_rb;
    assign rf_rx_addr = req_rx;

    opnd_agen_ea #(
        .DW(DW)
    ) u_ea (
        .mode      (req_mode),
        .size      (req_size),
        .base_val  (rf_rb_data),
        .index_val (rf_rx_data),
        .disp      (req_disp),
        .imm       (req_imm),
        .use_mem   (ea_use_mem),
        .chain     (ea_chain),
        .upd_en    (ea_upd_en),
        .upd_val   (ea_upd_val),
        .mem_ad    (ea_mem_ad),
        .direct_val(ea_direct)
    );

    opnd_agen_seq #(
        .DW (DW),
        .RAW(RAW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_rb     (req_rb),
        .first_val  (rf_ra_data),
        .use_mem    (ea_use_mem),
        .chain      (ea_chain),
        .upd_en     (ea_upd_en),
        .upd_val    (ea_upd_val),
        .mem_ad     (ea_mem_ad),
        .direct_val (ea_direct),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .out_valid  (out_valid),
        .out_operand(out_operand),
        .out_base   (out_base),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata)
    );

endmodule

// File: rtl/opnd_agen_chk.sv
module opnd_agen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic mem_re,
    input logic out_valid,
    input logic rf_we
);

    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> out_valid); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R10

    AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re); // R10

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R11

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> busy); // R11

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !busy); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(out_valid || mem_re || rf_we || busy)); // R12

endmodule

bind opnd_agen opnd_agen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .mem_re   (mem_re),
    .out_valid(out_valid),
    .rf_we    (rf_we)
);

// File: tb/sim_opnd_agen.sv
`timescale 1ns/1ps
module sim_opnd_agen;

    localparam int DW  = 16;
    localparam int RN  = 4;
    localparam int RAW = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid;
    logic [3:0]     req_mode;
    logic [1:0]     req_size;
    logic [RAW-1:0] req_ra, req_rb, req_rx;
    logic [DW-1:0]  req_disp, req_imm;
    logic           busy;
    logic [RAW-1:0] rf_ra_addr, rf_rb_addr, rf_rx_addr;
    logic [DW-1:0]  rf_ra_data, rf_rb_data, rf_rx_data;
    logic           rf_we;
    logic [RAW-1:0] rf_waddr;
    logic [DW-1:0]  rf_wdata;
    logic           mem_re;
    logic [DW-1:0]  mem_addr;
    logic [DW-1:0]  mem_rdata;
    logic           out_valid;
    logic [DW-1:0]  out_operand, out_base;

    logic [DW-1:0]  rf [RN];

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    opnd_agen #(.DW(DW), .RN(RN)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_size(req_size), .req_ra(req_ra), .req_rb(req_rb), .req_rx(req_rx),
        .req_disp(req_disp), .req_imm(req_imm), .busy(busy),
        .rf_ra_addr(rf_ra_addr), .rf_rb_addr(rf_rb_addr), .rf_rx_addr(rf_rx_addr),
        .rf_ra_data(rf_ra_data), .rf_rb_data(rf_rb_data), .rf_rx_data(rf_rx_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_operand(out_operand), .out_base(out_base)
    );

    assign rf_ra_data = rf[rf_ra_addr];
    assign rf_rb_data = rf[rf_rb_addr];
    assign rf_rx_data = rf[rf_rx_addr];

    // memory word at any byte address is a fixed function of that address
    function automatic logic [DW-1:0] fm(logic [DW-1:0] a);
        logic [31:0] p;
        p = 32'(a) * 32'd40503 + 32'd4321;
        return p[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] mix(int x);
        logic [31:0] p;
        p = 32'(x) * 32'd2654435761 + 32'd977;
        return p[DW+7:8];
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= fm(mem_addr);
    end

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic string tag(int m);
        case (m)
            1:       return "R2";
            2, 5:    return "R3";
            3, 4:    return "R4";
            6:       return "R5";
            7:       return "R6";
            8:       return "R7";
            9:       return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic run(int m, int sz, int ra, int rb, int rx, int t);
        logic [DW-1:0] vb, vx, va, st, dsp, im, a1, a2, opn, wd;
        logic [DW-1:0] seen [2];
        int  nrd, lat, cyc, ns;
        bit  we, got;
        string rq;

        for (int i = 0; i < RN; i++) rf[i] = mix(t * 8 + i);
        dsp = mix(t + 70000);
        im  = mix(t + 90000);
        req_mode  = 4'(m);
        req_size  = 2'(sz);
        req_ra    = RAW'(ra);
        req_rb    = RAW'(rb);
        req_rx    = RAW'(rx);
        req_disp  = dsp;
        req_imm   = im;
        req_valid = 1'b1;

        vb = rf[rb]; vx = rf[rx]; va = rf[ra];
        st = DW'(1) << sz;
        nrd = 1; we = 1'b0; wd = '0; opn = vb; a1 = '0; a2 = '0;
        case (m)
            1: begin nrd = 0; opn = im; end
            2: a1 = dsp + vb;
            3: a1 = vb;
            4: a1 = vb + vx;
            5: a1 = dsp;
            6: begin a1 = vb; nrd = 2; end
            7: begin a1 = vb; we = 1'b1; wd = vb + st; end
            8: begin a1 = vb - st; we = 1'b1; wd = vb - st; end
            9: a1 = dsp + vb + (vx << sz);
            default: begin nrd = 0; opn = vb; end
        endcase
        if (nrd >= 1) opn = fm(a1);
        if (nrd == 2) begin a2 = fm(a1); opn = fm(a2); end
        lat = (nrd == 0) ? 1 : (nrd == 1) ? 3 : 5;
        rq = tag(m);

        @(posedge clk);
        @(negedge clk);
        // conflicting request held while busy (R11)
        req_mode = 4'd1;
        req_imm  = ~im;
        req_rb   = RAW'(rb + 1);
        cyc = 1; ns = 0; got = 1'b0;
        while (!got && cyc <= 12) begin
            if (mem_re) begin
                if (ns < 2) seen[ns] = mem_addr;
                ns++;
            end
            if (out_valid) got = 1'b1;
            else begin
                @(negedge clk);
                cyc++;
            end
        end

        chk("R10", "done latency", 32'(cyc), 32'(lat));
        if (got) begin
            chk(rq,    "operand", 32'(out_operand), 32'(opn));
            chk("R11", "operand after ignored request", 32'(out_operand), 32'(opn));
            chk("R9",  "first register value", 32'(out_base), 32'(va));
            chk(we ? rq : "R10", "write strobe", 32'(rf_we), 32'(we));
            if (we) begin
                chk(rq, "write address", 32'(rf_waddr), 32'(rb));
                chk(rq, "write data", 32'(rf_wdata), 32'(wd));
            end
        end
        chk(rq, "read count", 32'(ns), 32'(nrd));
        if (nrd >= 1 && ns >= 1) chk(rq, "first read address", 32'(seen[0]), 32'(a1));
        if (nrd == 2 && ns >= 2) chk("R5", "second read address", 32'(seen[1]), 32'(a2));

        req_valid = 1'b0;
        @(negedge clk);
        chk("R11", "busy after done", 32'(busy), 32'd0);
        chk("R10", "done is one cycle", 32'(out_valid), 32'd0);
    endtask

    initial begin
        int t;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_mode  = '0;
        req_size  = '0;
        req_ra    = '0;
        req_rb    = '0;
        req_rx    = '0;
        req_disp  = '0;
        req_imm   = '0;
        for (int i = 0; i < RN; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R12", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R12", "reset busy", 32'(busy), 32'd0);
        chk("R12", "reset mem_re", 32'(mem_re), 32'd0);
        chk("R12", "reset rf_we", 32'(rf_we), 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        t = 0;
        for (int m = 0; m < 16; m++)
            for (int sz = 0; sz < 4; sz++)
                for (int ra = 0; ra < RN; ra++)
                    for (int rb = 0; rb < RN; rb++)
                        for (int rx = 0; rx < RN; rx++) begin
                            run(m, sz, ra, rb, rx, t);
                            t++;
                        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule